// File: doc/BRIEF.md
# Mode-Addressed Port Configuration Register Bank

This block holds the per-pin electrical configuration of three 8-bit I/O ports in a small microcontroller. It also holds the control word of an analog comparator that shares pins with port B. The CPU does not address these registers directly. It first loads a 4-bit selector (`mode_q`), then issues a configuration write that names a port and carries an 8-bit value. The selector chooses which kind of register the value lands in: pullup disable, input threshold, or Schmitt disable. Selector codes that belong to other register families are accepted on the selector path, and configuration writes under them leave this bank untouched.

Writes to the comparator control word are exchanges. The value the register held before the write, together with the live comparator result in bit 0, comes back on `rd_data` one cycle later. Every configuration write produces one `rd_valid` pulse. Targets that do not exist, and targets that are plain write-only, return 00h.

The pad logic consumes the control vectors directly. In each vector, port A occupies bits 7:0, port B bits 15:8 and port C bits 23:16.

Top module: `port_cfg_bank`

## Requirements
- R1: While `rst` is high and after it falls, every pullup, threshold and Schmitt bit reads 1. `cmp_disable` and `cmp_pin_off` read 1, `mode_q` reads 4'hF, `rd_data` reads 00h and `rd_valid` reads 0.
- R2: A cycle with `mode_wr` high loads `mode_din` into `mode_q` at that clock edge. Without `mode_wr`, `mode_q` holds its value.
- R3: With `mode_q` = 4'hE, a configuration write copies `cfg_din` into the pullup-disable byte of the port named by `cfg_port` (0=A, 1=B, 2=C). The other ports' bytes are unchanged.
- R4: With `mode_q` = 4'hD, a configuration write copies `cfg_din` into the threshold byte of the named port (1 = TTL, 0 = CMOS).
- R5: With `mode_q` = 4'hC, a configuration write to port B or C copies `cfg_din` into that port's Schmitt-disable byte (1 = disabled). A write to port A is ignored, and the port A byte stays FFh.
- R6: With `mode_q` = 4'h8, a write to port B stores `cfg_din[7:1]`. `cmp_disable` then follows stored bit 7 (0 enables the comparator) and `cmp_pin_off` follows stored bit 6 (0 drives the result onto pin 0 of port B). `cfg_din[0]` is discarded.
- R7: One cycle after a comparator write, `rd_data` holds the previously stored bits 7:1, with bit 0 equal to `cmp_in` as sampled at the write edge. `rd_valid` is high for exactly the one cycle after each configuration write.
- R8: A configuration write leaves every output vector unchanged and returns 00h in each of these cases: `cfg_port` = 3, selector 4'h8 on port A or C, or any selector code other than 8h, Ch, Dh and Eh.
- R9: Writes to the pullup, threshold and Schmitt registers return 00h on `rd_data`.
- R10: When `mode_wr` and `cfg_wr` are high in the same cycle, the configuration write is decoded with the selector value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Load strobe for the selector |
| mode_din | input | 4 | New selector value |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_port | input | 2 | Port index: 0=A, 1=B, 2=C |
| cfg_din | input | 8 | Working value written |
| cmp_in | input | 1 | Comparator result from the analog block |
| mode_q | output | 4 | Current selector |
| pull_dis | output | 24 | Pullup disable, 1 bit per pin |
| ttl_sel | output | 24 | Input threshold select, 1 = TTL |
| st_dis | output | 24 | Schmitt disable, 1 bit per pin |
| cmp_disable | output | 1 | Comparator off when 1 |
| cmp_pin_off | output | 1 | Result not driven onto the pin when 1 |
| rd_data | output | 8 | Exchange read-back value |
| rd_valid | output | 1 | Read-back qualifier, one cycle per write |

## Verification
The hardest case to reach from the ports is a selector load and a configuration write that land on the same edge. The result depends on which selector value the decoder sees. The bench fires both strobes together while the selector points at the comparator and the new selector points at the pullups. It then checks that the comparator exchanged and that the pullups did not move. Comparator exchanges are also issued with `cmp_in` set opposite to the written bit 0. This shows that bit 0 of the read-back comes from the live input and never from stored data.

// File: rtl/port_cfg_pkg.sv
`timescale 1ns/1ps
package port_cfg_pkg;

  // Selector codes that land in this bank
  localparam int CODE_CMP     = 8;
  localparam int CODE_SCHMITT = 12;
  localparam int CODE_LEVEL   = 13;
  localparam int CODE_PULL    = 14;
  localparam int CODE_RESET   = 15;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_PULL,
    TGT_LEVEL,
    TGT_SCHMITT,
    TGT_CMP
  } cfg_tgt_e;

endpackage

// File: rtl/port_cfg_decode.sv
`timescale 1ns/1ps
module port_cfg_decode
  import port_cfg_pkg::*;
#(
  parameter int                 NPORTS   = 3,
  parameter int                 MODE_W   = 4,
  parameter int                 SEL_W    = 2,
  parameter logic [NPORTS-1:0]  ST_MASK  = 3'b110,
  parameter int                 CMP_PORT = 1
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [SEL_W-1:0]  port_sel,
  output cfg_tgt_e          tgt,
  output logic [NPORTS-1:0] port_oh
);

  logic [NPORTS-1:0] oh_raw;
  logic              port_ok;
  logic              st_here;
  logic              cmp_here;

  for (genvar i = 0; i < NPORTS; i++) begin : g_oh
    assign oh_raw[i] = (int'(port_sel) == i);
  end

  assign port_ok  = |oh_raw;
  assign st_here  = |(oh_raw & ST_MASK);
  assign cmp_here = oh_raw[CMP_PORT];

  always_comb begin
    tgt = TGT_NONE;
    if (port_ok) begin
      case (int'(mode))
        CODE_PULL:    tgt = TGT_PULL;
        CODE_LEVEL:   tgt = TGT_LEVEL;
        CODE_SCHMITT: if (st_here)  tgt = TGT_SCHMITT;
        CODE_CMP:     if (cmp_here) tgt = TGT_CMP;
        default:      tgt = TGT_NONE;
      endcase
    end
  end

  assign port_oh = (tgt != TGT_NONE) ? oh_raw : '0;

endmodule

// File: rtl/port_cfg_regs.sv
`timescale 1ns/1ps
module port_cfg_regs #(
  parameter int                NPORTS  = 3,
  parameter int                W       = 8,
  parameter logic [NPORTS-1:0] PRESENT = '1,
  parameter logic [W-1:0]      RST_VAL = '1,
  localparam int               VEC_W   = NPORTS * W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [NPORTS-1:0] port_oh,
  input  logic [W-1:0]      din,
  output logic [VEC_W-1:0]  q
);

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    logic [W-1:0] r;
    logic         hit;
    // absent ports keep their reset value forever
    assign hit = we && port_oh[i] && PRESENT[i];
    always_ff @(posedge clk) begin
      if (rst)      r <= RST_VAL;
      else if (hit) r <= din;
    end
    assign q[i*W +: W] = r;
  end

endmodule

// File: rtl/port_cfg_cmp.sv
`timescale 1ns/1ps
module port_cfg_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:1] din_hi,
  input  logic         cmp_in,
  output logic         cmp_disable,
  output logic         cmp_pin_off,
  output logic [W-1:0] view
);

  logic [W-1:1] ctl_q;

  always_ff @(posedge clk) begin
    if (rst)     ctl_q <= '1;
    else if (we) ctl_q <= din_hi;
  end

  assign cmp_disable = ctl_q[W-1];
  assign cmp_pin_off = ctl_q[W-2];
  // bit 0 is never stored; it mirrors the live result
  assign view = {ctl_q, cmp_in};

endmodule

// File: rtl/port_cfg_bank.sv
`timescale 1ns/1ps
module port_cfg_bank
  import port_cfg_pkg::*;
#(
  parameter int                NPORTS   = 3,
  parameter int                W        = 8,
  parameter int                MODE_W   = 4,
  parameter int                SEL_W    = 2,
  parameter logic [NPORTS-1:0] ST_MASK  = 3'b110,
  parameter int                CMP_PORT = 1,
  localparam int               VEC_W    = NPORTS * W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_din,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_port,
  input  logic [W-1:0]      cfg_din,
  input  logic              cmp_in,
  output logic [MODE_W-1:0] mode_q,
  output logic [VEC_W-1:0]  pull_dis,
  output logic [VEC_W-1:0]  ttl_sel,
  output logic [VEC_W-1:0]  st_dis,
  output logic              cmp_disable,
  output logic              cmp_pin_off,
  output logic [W-1:0]      rd_data,
  output logic              rd_valid
);

  localparam logic [MODE_W-1:0] MODE_RST = MODE_W'(CODE_RESET);
  localparam logic [W-1:0]      ONES     = '1;

  cfg_tgt_e          tgt;
  logic [NPORTS-1:0] port_oh;
  logic [W-1:0]      cmp_view;
  logic              we_pull, we_level, we_st, we_cmp;

  // selector register
  always_ff @(posedge clk) begin
    if (rst)          mode_q <= MODE_RST;
    else if (mode_wr) mode_q <= mode_din;
  end

  port_cfg_decode #(
    .NPORTS(NPORTS), .MODE_W(MODE_W), .SEL_W(SEL_W),
    .ST_MASK(ST_MASK), .CMP_PORT(CMP_PORT)
  ) u_dec (
    .mode    (mode_q),
    .port_sel(cfg_port),
    .tgt     (tgt),
    .port_oh (port_oh)
  );

  assign we_pull  = cfg_wr && (tgt == TGT_PULL);
  assign we_level = cfg_wr && (tgt == TGT_LEVEL);
  assign we_st    = cfg_wr && (tgt == TGT_SCHMITT);
  assign we_cmp   = cfg_wr && (tgt == TGT_CMP);

  port_cfg_regs #(.NPORTS(NPORTS), .W(W), .PRESENT('1), .RST_VAL(ONES)) u_pull (
    .clk(clk), .rst(rst), .we(we_pull), .port_oh(port_oh), .din(cfg_din), .q(pull_dis)
  );

  port_cfg_regs #(.NPORTS(NPORTS), .W(W), .PRESENT('1), .RST_VAL(ONES)) u_level (
    .clk(clk), .rst(rst), .we(we_level), .port_oh(port_oh), .din(cfg_din), .q(ttl_sel)
  );

  port_cfg_regs #(.NPORTS(NPORTS), .W(W), .PRESENT(ST_MASK), .RST_VAL(ONES)) u_st (
    .clk(clk), .rst(rst), .we(we_st), .port_oh(port_oh), .din(cfg_din), .q(st_dis)
  );

  port_cfg_cmp #(.W(W)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .we         (we_cmp),
    .din_hi     (cfg_din[W-1:1]),
    .cmp_in     (cmp_in),
    .cmp_disable(cmp_disable),
    .cmp_pin_off(cmp_pin_off),
    .view       (cmp_view)
  );

  // exchange read-back: old comparator word, zero for all else
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= cfg_wr;
      if (cfg_wr) rd_data <= (tgt == TGT_CMP) ? cmp_view : '0;
    end
  end

endmodule

// File: rtl/port_cfg_bank_chk.sv
`timescale 1ns/1ps
module port_cfg_bank_chk
  import port_cfg_pkg::*;
#(
  parameter int  NPORTS   = 3,
  parameter int  W        = 8,
  parameter int  MODE_W   = 4,
  parameter int  SEL_W    = 2,
  parameter int  CMP_PORT = 1,
  localparam int VEC_W    = NPORTS * W
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_wr,
  input logic [MODE_W-1:0] mode_din,
  input logic              cfg_wr,
  input logic [SEL_W-1:0]  cfg_port,
  input logic [W-1:0]      cfg_din,
  input logic              cmp_in,
  input logic [MODE_W-1:0] mode_q,
  input logic [VEC_W-1:0]  pull_dis,
  input logic [VEC_W-1:0]  ttl_sel,
  input logic [VEC_W-1:0]  st_dis,
  input logic              cmp_disable,
  input logic              cmp_pin_off,
  input logic [W-1:0]      rd_data,
  input logic              rd_valid
);

  p_mode_load_r2: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> mode_q == $past(mode_din));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !mode_wr |=> $stable(mode_q));

  p_pull_write_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && int'(mode_q) == CODE_PULL && cfg_port == '0)
      |=> pull_dis[W-1:0] == $past(cfg_din));

  p_pull_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !(cfg_wr && int'(mode_q) == CODE_PULL) |=> $stable(pull_dis));

  p_st_port_a_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && int'(mode_q) == CODE_SCHMITT && cfg_port == '0) |=> $stable(st_dis));

  p_cmp_exchange_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && int'(mode_q) == CODE_CMP && cfg_port == SEL_W'(CMP_PORT))
      |=> (rd_data[W-1] == $past(cmp_disable) && rd_data[W-2] == $past(cmp_pin_off)
           && rd_data[0] == $past(cmp_in)));

  p_valid_after_wr_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> rd_valid);

  p_valid_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> !rd_valid);

  p_foreign_mode_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !(int'(mode_q) inside {CODE_CMP, CODE_SCHMITT, CODE_LEVEL, CODE_PULL}))
      |=> (rd_data == '0 && $stable(pull_dis) && $stable(ttl_sel) && $stable(st_dis)
           && $stable(cmp_disable) && $stable(cmp_pin_off)));

endmodule

bind port_cfg_bank port_cfg_bank_chk #(
  .NPORTS(NPORTS), .W(W), .MODE_W(MODE_W), .SEL_W(SEL_W), .CMP_PORT(CMP_PORT)
) u_chk (.*);

// File: tb/port_cfg_bank_tb.sv
`timescale 1ns/1ps
module port_cfg_bank_tb;

  localparam int W      = 8;
  localparam int MODE_W = 4;
  localparam int SEL_W  = 2;
  localparam int VEC_W  = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mode_wr = 1'b0;
  logic [MODE_W-1:0] mode_din = '0;
  logic              cfg_wr = 1'b0;
  logic [SEL_W-1:0]  cfg_port = '0;
  logic [W-1:0]      cfg_din = '0;
  logic              cmp_in = 1'b0;
  logic [MODE_W-1:0] mode_q;
  logic [VEC_W-1:0]  pull_dis, ttl_sel, st_dis;
  logic              cmp_disable, cmp_pin_off;
  logic [W-1:0]      rd_data;
  logic              rd_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] exp_data[$];
  string        exp_req[$];

  always #2.5 clk = ~clk;

  port_cfg_bank u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one cycle of strobes, expected read-back pushed to the scoreboard
  task automatic drive(bit mw, logic [MODE_W-1:0] md, bit cw, logic [SEL_W-1:0] cp,
                       logic [W-1:0] cd, bit cmpv, string req, logic [W-1:0] exp_rd);
    @(negedge clk);
    mode_wr  = mw;
    mode_din = md;
    cfg_wr   = cw;
    cfg_port = cp;
    cfg_din  = cd;
    cmp_in   = cmpv;
    if (cw) begin
      exp_data.push_back(exp_rd);
      exp_req.push_back(req);
    end
    @(negedge clk);
    mode_wr = 1'b0;
    cfg_wr  = 1'b0;
  endtask

  task automatic set_mode(logic [MODE_W-1:0] md);
    drive(1'b1, md, 1'b0, '0, '0, cmp_in, "R2", '0);
    check("R2 selector load", 32'(mode_q), 32'(md));
  endtask

  // monitor: pops one expected item per read-back pulse
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_data.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R7 unexpected rd_valid actual=1 expected=0");
      end else begin
        check({exp_req.pop_front(), " read-back"}, 32'(rd_data), 32'(exp_data.pop_front()));
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rd_valid", 32'(rd_valid), 0);
    rst = 1'b0;
    check("R1 reset pull", 32'(pull_dis), 32'hFFFFFF);
    check("R1 reset level", 32'(ttl_sel), 32'hFFFFFF);
    check("R1 reset schmitt", 32'(st_dis), 32'hFFFFFF);
    check("R1 reset selector", 32'(mode_q), 32'hF);
    check("R1 reset cmp", 32'({cmp_disable, cmp_pin_off}), 32'h3);
    check("R1 reset rd_data", 32'(rd_data), 0);

    // selector still at reset code: write goes nowhere
    drive(1'b0, '0, 1'b1, 2'd1, 8'h55, 1'b0, "R8", 8'h00);
    check("R8 reset-code write pull", 32'(pull_dis), 32'hFFFFFF);
    check("R8 reset-code write level", 32'(ttl_sel), 32'hFFFFFF);

    set_mode(4'hE);
    drive(1'b0, '0, 1'b1, 2'd0, 8'h12, 1'b0, "R9", 8'h00);
    check("R3 pull port A only", 32'(pull_dis), 32'hFFFF12);
    drive(1'b0, '0, 1'b1, 2'd1, 8'h34, 1'b0, "R9", 8'h00);
    drive(1'b0, '0, 1'b1, 2'd2, 8'h56, 1'b0, "R9", 8'h00);
    check("R3 pull all ports", 32'(pull_dis), 32'h563412);
    check("R3 level untouched", 32'(ttl_sel), 32'hFFFFFF);

    set_mode(4'hD);
    drive(1'b0, '0, 1'b1, 2'd1, 8'hA5, 1'b0, "R9", 8'h00);
    check("R4 level port B", 32'(ttl_sel), 32'hFFA5FF);
    check("R4 pull untouched", 32'(pull_dis), 32'h563412);

    set_mode(4'hC);
    drive(1'b0, '0, 1'b1, 2'd0, 8'h00, 1'b0, "R5", 8'h00);
    check("R5 schmitt port A ignored", 32'(st_dis), 32'hFFFFFF);
    drive(1'b0, '0, 1'b1, 2'd2, 8'h3C, 1'b0, "R5", 8'h00);
    check("R5 schmitt port C", 32'(st_dis), 32'h3CFFFF);

    set_mode(4'h8);
    drive(1'b0, '0, 1'b1, 2'd1, 8'h3E, 1'b1, "R7", 8'hFF);
    check("R6 cmp enabled and routed", 32'({cmp_disable, cmp_pin_off}), 32'h0);
    drive(1'b0, '0, 1'b1, 2'd1, 8'h81, 1'b0, "R7", 8'h3E);
    check("R6 cmp disabled, routed", 32'({cmp_disable, cmp_pin_off}), 32'h2);
    drive(1'b0, '0, 1'b1, 2'd1, 8'h40, 1'b1, "R6 bit0 discarded", 8'h81);
    check("R6 cmp enabled, not routed", 32'({cmp_disable, cmp_pin_off}), 32'h1);

    drive(1'b0, '0, 1'b1, 2'd0, 8'hFF, 1'b1, "R8", 8'h00);
    check("R8 cmp on port A ignored", 32'({cmp_disable, cmp_pin_off}), 32'h1);
    drive(1'b0, '0, 1'b1, 2'd3, 8'h80, 1'b1, "R8", 8'h00);
    check("R8 port 3 ignored", 32'({cmp_disable, cmp_pin_off}), 32'h1);

    // same-edge selector load and comparator write
    drive(1'b1, 4'hE, 1'b1, 2'd1, 8'hC2, 1'b0, "R10", 8'h40);
    check("R10 new selector", 32'(mode_q), 32'hE);
    check("R10 pull untouched", 32'(pull_dis), 32'h563412);
    check("R10 cmp written", 32'({cmp_disable, cmp_pin_off}), 32'h3);

    set_mode(4'h9);
    drive(1'b0, '0, 1'b1, 2'd1, 8'h00, 1'b0, "R8", 8'h00);
    check("R8 foreign code pull", 32'(pull_dis), 32'h563412);
    check("R8 foreign code schmitt", 32'(st_dis), 32'h3CFFFF);

    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", 32'(exp_data.size()), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule